// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block is a first-in first-out buffer between two unrelated clock domains. A producer pushes words on its own write clock and a consumer pops them on a separate read clock. The storage is a dual-port array of `DEPTH` words of `DATA_W` bits each. `DEPTH` must be a power of two and at least 4.

Both the read and the write pointer carry one extra wrap bit. Each pointer crosses into the other domain as Gray code through a two-stage synchroniser. The full flag is computed and registered in the write domain, and the empty flag in the read domain. Pushes into a full buffer and pops from an empty one are refused inside the block, so the pointers and the stored words stay intact.

A `rewind` pulse moves the read pointer back to array location 0. After a rewind, everything written since the last reset can be read again in its original order, provided no more than `DEPTH` words have been written since that reset. The read data sits in an output register. An output-enable input forces the data port to zero without disturbing that register.

Top module: `dual_clock_replay_fifo`

## Requirements
- R1: While `rst_n` is low, and after it rises, `empty` reads 1, `full` reads 0 and `rd_data` reads 0 with `oe_n` low. Pushes or pops presented while `rst_n` is low leave nothing stored.
- R2: A word is stored on a rising `wr_clk` edge where `wr_en_n` is 0 and `full` is 0. Words are returned in the order they were stored.
- R3: A push at an edge where `full` is 1, or a pop at an edge where `empty` is 1, changes neither the stored contents nor the pointer of that side.
- R4: `full` changes only on `wr_clk` edges and `empty` only on `rd_clk` edges. `full` becomes 1 at the write edge that stores the word bringing the unread count to `DEPTH`. `empty` becomes 1 at the read edge that takes the last unread word.
- R5: A pop attempted while `empty` is 1 leaves `rd_data` at the last word that was validly read.
- R6: When `rewind` is 1 at a rising `rd_clk` edge, the read pointer returns to location 0 and `empty` is 1 after that edge, and any pop requested in that cycle is suppressed. At the next read edge, `empty` goes to 0 if at least one word was written since reset. The following pops return the words written since reset, oldest first.
- R7: `rd_data` equals the output register while `oe_n` is 0 and is all zeros while `oe_n` is 1. Toggling `oe_n` does not alter the register.
- R8: After a rising `rd_clk` edge with `rd_en_n` 0 and `empty` 0, `rd_data` shows the popped word. The read pointer advances by exactly one.
- R9: With no pop, `empty` falls on the third rising `rd_clk` edge after the write edge that stored a word into an empty buffer. With no push, `full` falls on the third rising `wr_clk` edge after the read edge that took a word from a full buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en_n | input | 1 | Active-low push request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | Buffer full, write-clock domain |
| rd_en_n | input | 1 | Active-low pop request |
| rewind | input | 1 | Active-high request to move the read pointer back to location 0 |
| oe_n | input | 1 | Active-low output enable for `rd_data` |
| rd_data | output | DATA_W | Output register value, or zero when disabled |
| empty | output | 1 | Buffer empty, read-clock domain |

## Verification
The output register and the pop side of `empty` respond at the very read edge that accepts a pop or a rewind. The bench samples these 3 ns after that edge, before the next read edge. `full` responds at the write edge that stores the filling word, and the bench samples it 2 ns after that edge. The crossing delays are counted edge by edge in the receiving domain: two synchroniser stages plus the flag register put the change on the third edge. The bench samples one edge earlier to see the flag unchanged and then on the third edge to see it move. The two clocks are phased so that their rising edges never coincide, which keeps each count exact.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Action taken by the read side at a read-clock edge.
  typedef enum logic [1:0] {
    RA_IDLE   = 2'd0,
    RA_POP    = 2'd1,
    RA_REWIND = 2'd2
  } rd_action_e;

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0] arr [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];

endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
  parameter int AW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_req,
  input  logic [AW:0] rd_gray_s,
  output logic [AW:0] wr_bin,
  output logic [AW:0] wr_gray,
  output logic        full,
  output logic        we,
  output logic [AW-1:0] waddr
);

  localparam int PW = AW + 1;
  localparam logic [PW-1:0] TOP2 = {2'b11, {(PW-2){1'b0}}};

  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          full_q, full_d, push;

  always_comb begin
    push   = wr_req & ~full_q;
    bin_d  = bin_q + PW'(push);
    gray_d = (bin_d >> 1) ^ bin_d;
    // Full when the write pointer leads the read pointer by one whole lap.
    full_d = (gray_d == (rd_gray_s ^ TOP2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
      full_q <= 1'b0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
      full_q <= full_d;
    end
  end

  assign wr_bin  = bin_q;
  assign wr_gray = gray_q;
  assign full    = full_q;
  assign we      = push;
  assign waddr   = bin_q[AW-1:0];

endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          rewind,
  input  logic [AW:0]   wr_gray_s,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW:0]   rd_bin,
  output logic [AW:0]   rd_gray,
  output logic          empty,
  output logic [AW-1:0] raddr,
  output logic [W-1:0]  rd_q
);

  localparam int PW = AW + 1;

  rd_action_e    act;
  logic [PW-1:0] bin_q, bin_d, gray_q, gray_d;
  logic          empty_q, empty_d;
  logic [W-1:0]  q_q, q_d;

  always_comb begin
    if (rewind)                 act = RA_REWIND;
    else if (rd_req && !empty_q) act = RA_POP;
    else                        act = RA_IDLE;

    bin_d = bin_q;
    q_d   = q_q;
    case (act)
      RA_POP: begin
        bin_d = bin_q + 1'b1;
        q_d   = mem_rdata;
      end
      RA_REWIND: bin_d = '0;
      default: ;
    endcase

    gray_d = (bin_d >> 1) ^ bin_d;
    // A rewind forces one empty cycle; occupancy is recomputed on the next edge.
    empty_d = (act == RA_REWIND) ? 1'b1 : (gray_d == wr_gray_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q   <= '0;
      gray_q  <= '0;
      empty_q <= 1'b1;
      q_q     <= '0;
    end else begin
      bin_q   <= bin_d;
      gray_q  <= gray_d;
      empty_q <= empty_d;
      q_q     <= q_d;
    end
  end

  assign rd_bin  = bin_q;
  assign rd_gray = gray_q;
  assign empty   = empty_q;
  assign raddr   = bin_q[AW-1:0];
  assign rd_q    = q_q;

endmodule

// File: rtl/dual_clock_replay_fifo.sv
module dual_clock_replay_fifo #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 64
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  input  logic              rd_en_n,
  input  logic              rewind,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic              wr_rst_n_s, rd_rst_n_s;
  logic [PW-1:0]     wr_bin, wr_gray, rd_bin, rd_gray;
  logic [PW-1:0]     wr_gray_rs, rd_gray_ws;
  logic              we;
  logic [AW-1:0]     waddr, raddr;
  logic [DATA_W-1:0] mem_rdata, rd_q;

  // Reset release, one synchroniser per domain.
  dcf_sync #(.W(1), .STAGES(2)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n_s)
  );
  dcf_sync #(.W(1), .STAGES(2)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n_s)
  );

  // Gray pointer crossings.
  dcf_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n_s), .d(wr_gray), .q(wr_gray_rs)
  );
  dcf_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n_s), .d(rd_gray), .q(rd_gray_ws)
  );

  dcf_wr_ctl #(.AW(AW)) u_wr (
    .clk      (wr_clk),
    .rst_n    (wr_rst_n_s),
    .wr_req   (~wr_en_n),
    .rd_gray_s(rd_gray_ws),
    .wr_bin   (wr_bin),
    .wr_gray  (wr_gray),
    .full     (full),
    .we       (we),
    .waddr    (waddr)
  );

  dcf_mem #(.W(DATA_W), .AW(AW)) u_mem (
    .wr_clk(wr_clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (mem_rdata)
  );

  dcf_rd_ctl #(.W(DATA_W), .AW(AW)) u_rd (
    .clk      (rd_clk),
    .rst_n    (rd_rst_n_s),
    .rd_req   (~rd_en_n),
    .rewind   (rewind),
    .wr_gray_s(wr_gray_rs),
    .mem_rdata(mem_rdata),
    .rd_bin   (rd_bin),
    .rd_gray  (rd_gray),
    .empty    (empty),
    .raddr    (raddr),
    .rd_q     (rd_q)
  );

  assign rd_data = oe_n ? '0 : rd_q;

endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n_s,
  input logic          rd_rst_n_s,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          rewind,
  input logic          full,
  input logic          empty,
  input logic [AW:0]   wr_bin,
  input logic [AW:0]   rd_bin,
  input logic [W-1:0]  rd_q
);

  // R3
  no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
    full |=> (wr_bin == $past(wr_bin)));

  // R3
  no_underflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
    (empty && !rewind) |=> (rd_bin == $past(rd_bin)));

  // R2
  push_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n_s)
    (!wr_en_n && !full) |=> (wr_bin == (AW+1)'($past(wr_bin) + 1'b1)));

  // R8
  pop_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
    (!rd_en_n && !empty && !rewind) |=> (rd_bin == (AW+1)'($past(rd_bin) + 1'b1)));

  // R5
  hold_on_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
    empty |=> $stable(rd_q));

  // R6
  rewind_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n_s)
    rewind |=> (rd_bin == '0) && empty);

endmodule

bind dual_clock_replay_fifo dcf_chk #(.W(DATA_W), .AW(AW)) u_chk (
  .wr_clk    (wr_clk),
  .rd_clk    (rd_clk),
  .wr_rst_n_s(wr_rst_n_s),
  .rd_rst_n_s(rd_rst_n_s),
  .wr_en_n   (wr_en_n),
  .rd_en_n   (rd_en_n),
  .rewind    (rewind),
  .full      (full),
  .empty     (empty),
  .wr_bin    (wr_bin),
  .rd_bin    (rd_bin),
  .rd_q      (rd_q)
);

// File: tb/sim_dual_clock_replay_fifo.sv
module sim_dual_clock_replay_fifo;

  localparam int W = 18;
  localparam int DEPTH = 16;

  logic wr_clk, rd_clk, rst_n, wr_en_n, rd_en_n, rewind, oe_n;
  logic [W-1:0] wr_data, rd_data;
  logic full, empty;

  int n_run = 0;
  int n_fail = 0;
  logic [W-1:0] mq[$];
  logic [W-1:0] hist[$];
  logic [W-1:0] last;

  dual_clock_replay_fifo #(.DATA_W(W), .DEPTH(DEPTH)) u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .full(full),
    .rd_en_n(rd_en_n), .rewind(rewind), .oe_n(oe_n),
    .rd_data(rd_data), .empty(empty)
  );

  // 100 MHz write clock, rising edges at 5+10k ns.
  initial begin
    wr_clk = 1'b0;
    forever #5 wr_clk = ~wr_clk;
  end

  // Read clock, rising edges at 2+14k ns: never coincident with write edges.
  initial begin
    rd_clk = 1'b0;
    #2 rd_clk = 1'b1;
    forever #7 rd_clk = ~rd_clk;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(input logic en, input logic [W-1:0] d);
    logic f;
    @(negedge wr_clk);
    wr_en_n = !en;
    wr_data = d;
    f = full;
    @(posedge wr_clk);
    if (en && !f) begin
      mq.push_back(d);
      hist.push_back(d);
    end
  endtask

  task automatic rd_cycle(input logic en);
    logic e;
    logic [W-1:0] exp;
    @(negedge rd_clk);
    rd_en_n = !en;
    e = empty;
    @(posedge rd_clk);
    #3;
    if (en) begin
      if (!e) begin
        if (mq.size() == 0) begin
          chk("R2 pop with no stored word", {63'd0, e}, 64'd1);
        end else begin
          exp = mq.pop_front();
          chk("R2 order", rd_data, exp);
          last = exp;
        end
      end else begin
        chk("R5 hold on empty", rd_data, last);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    rst_n = 1'b1;
    repeat (8) @(negedge rd_clk);
    mq.delete();
    hist.delete();
    last = '0;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge wr_clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] exp;
    void'($urandom(32'd2024));
    last = '0;
    rst_n = 1'b0;
    oe_n = 1'b0;
    rewind = 1'b0;
    wr_en_n = 1'b0;
    rd_en_n = 1'b0;
    wr_data = 18'h15A5A;
    // R1: requests held active while in reset must not store anything.
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    rd_en_n = 1'b1;
    rst_n = 1'b1;
    repeat (8) @(negedge rd_clk);
    chk("R1 empty after reset", {63'd0, empty}, 64'd1);
    chk("R1 full after reset", {63'd0, full}, 64'd0);
    chk("R1 data after reset", rd_data, 0);
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    chk("R3 pop on empty blocked", {63'd0, empty}, 64'd1);

    // R9: empty falls on the third read edge after the storing write edge.
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = 18'h0C0DE;
    @(posedge wr_clk);
    fork begin #1 wr_en_n = 1'b1; end join_none
    mq.push_back(18'h0C0DE);
    @(posedge rd_clk);
    @(posedge rd_clk);
    #3 chk("R9 empty still set after two read edges", {63'd0, empty}, 64'd1);
    @(posedge rd_clk);
    #3 chk("R9 empty clear on third read edge", {63'd0, empty}, 64'd0);
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    chk("R4 empty on last pop", {63'd0, empty}, 64'd1);

    // Random concurrent traffic (R2, R3, R5).
    fork
      begin
        for (int i = 0; i < 400; i++) wr_cycle(($urandom % 4) != 0, W'($urandom));
        wr_cycle(1'b0, '0);
      end
      begin
        for (int i = 0; i < 400; i++) rd_cycle(($urandom % 2) == 1);
        rd_cycle(1'b0);
      end
    join
    repeat (6) @(posedge rd_clk);
    for (int k = 0; k < 64 && mq.size() > 0; k++) rd_cycle(1'b1);
    chk("R4 empty after draining", {63'd0, empty}, 64'd1);
    rd_cycle(1'b0);
    chk("R2 all words returned", mq.size(), 0);

    // Fill to the brim (R4), then a blocked push (R3).
    repeat (6) @(posedge wr_clk);
    for (int i = 0; i < DEPTH; i++) begin
      wr_cycle(1'b1, W'(18'h100 + i));
      #2;
      if (i == DEPTH - 2) chk("R4 full not yet set", {63'd0, full}, 64'd0);
    end
    chk("R4 full at filling write", {63'd0, full}, 64'd1);
    wr_cycle(1'b1, 18'h3ABCD);
    wr_cycle(1'b0, '0);
    #2 chk("R3 full holds after blocked push", {63'd0, full}, 64'd1);

    // R9: full falls on the third write edge after one pop.
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    fork begin #1 rd_en_n = 1'b1; end join_none
    exp = mq.pop_front();
    @(posedge wr_clk);
    @(posedge wr_clk);
    #2 chk("R9 full still set after two write edges", {63'd0, full}, 64'd1);
    @(posedge wr_clk);
    #2 chk("R9 full clear on third write edge", {63'd0, full}, 64'd0);
    chk("R8 popped word on output", rd_data, exp);
    last = exp;
    for (int i = 0; i < DEPTH - 1; i++) rd_cycle(1'b1);
    rd_cycle(1'b1);
    rd_cycle(1'b1);
    rd_cycle(1'b0);
    chk("R3 blocked push left nothing", {63'd0, empty}, 64'd1);

    // R7: output enable.
    @(negedge rd_clk);
    oe_n = 1'b1;
    #1 chk("R7 disabled output is zero", rd_data, 0);
    oe_n = 1'b0;
    #1 chk("R7 register kept while disabled", rd_data, last);

    // R6: rewind and replay.
    do_reset();
    for (int i = 0; i < 10; i++) wr_cycle(1'b1, W'(18'h2000 + i * 7));
    wr_cycle(1'b0, '0);
    repeat (6) @(posedge rd_clk);
    for (int i = 0; i < 4; i++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    @(negedge rd_clk);
    rewind = 1'b1;
    rd_en_n = 1'b0;
    @(posedge rd_clk);
    #3 chk("R6 empty after rewind edge", {63'd0, empty}, 64'd1);
    chk("R6 pop suppressed during rewind", rd_data, last);
    @(negedge rd_clk);
    rewind = 1'b0;
    rd_en_n = 1'b1;
    @(posedge rd_clk);
    #3 chk("R6 empty clear on next edge", {63'd0, empty}, 64'd0);
    mq.delete();
    foreach (hist[i]) mq.push_back(hist[i]);
    for (int i = 0; i < 10; i++) rd_cycle(1'b1);
    rd_cycle(1'b0);
    chk("R6 replay complete", {63'd0, empty}, 64'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule